// File: doc/BRIEF.md
# Scanned Door-Status Blink Monitor

This block reports the state of eight door contacts to eight indicator lamps at a remote guard post. The two ends share only a 3-bit slot number and one serial bit. A slot counter steps through the doors one at a time. At the door end, the slot number picks one contact and places its state on the serial bit. At the guard end, the same slot number sends that bit to the matching lamp output. The lamp outputs are active LOW.

No separate blink generator is used. The blinking comes from the scan itself. A lamp can only light while its own slot is selected, so an open door flashes once per scan and a closed door leaves its lamp dark. Only one lamp can ever be lit at a time.

The block runs on a fast system clock. The scan advances on a one-cycle `scanTick` pulse, so no clock is gated. With a 20 Hz tick and eight slots, each open door's lamp blinks at 2.5 Hz. Debouncing, lamp current drive and the cable itself belong to other blocks.

Top module: `door_scan_monitor`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) forces `scanSel` to 0 and all `ledN` bits HIGH (all lamps off).
- R2: `scanSel` advances by exactly one on each clock edge at which `scanTick` is high, and holds its value at every other edge.
- R3: After slot NUM_DOORS-1, the next tick returns `scanSel` to 0.
- R4: `serialBit` equals `doorClosed[scanSel]` with no register in the path. A value of 1 means the contacts are closed; 0 means the door is open.
- R5: One clock edge after any cycle, the `ledN` bit at the slot that was selected in that cycle equals the `serialBit` of that cycle. The lamp is therefore lit (LOW) exactly when the door was open.
- R6: Every `ledN` bit other than the previously selected slot is HIGH.
- R7: At most one `ledN` bit is LOW at any time.
- R8: With ticks evenly spaced T clocks apart, over any NUM_DOORS*T consecutive clocks:
  - the lamp of each closed door is never LOW;
  - the lamp of each open door is LOW for exactly T clocks.
  A 20 Hz tick with eight doors therefore gives a 2.5 Hz blink.
- R9: Changing the contact of a door that is not selected has no effect on `ledN`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scanTick | input | 1 | One-cycle pulse that advances the scan slot |
| doorClosed | input | NUM_DOORS | Door contacts: 1 = closed, 0 = open |
| ledN | output | NUM_DOORS | Active-LOW lamp drives, registered |
| scanSel | output | $clog2(NUM_DOORS) | Current slot (shared select lines) |
| serialBit | output | 1 | Contact state of the selected door |

## Verification
`scanSel` changes one edge after a sampled tick, and `serialBit` follows the door inputs and `scanSel` with no delay. `ledN` reflects the slot and contact value seen at the previous edge, so each lamp lags the select by one clock. The bench keeps a reference model that is updated right after each rising edge from its own inputs only. It compares all three outputs at the following falling edge, so every check falls in the cycle where that result is due. The blink-duty check counts LOW cycles over a full window of ticks spaced a fixed number of clocks apart.

// File: rtl/door_scan_pkg.sv
package door_scan_pkg;
  // Strobes from scan control to the lamp datapath
  typedef struct packed {
    logic clearOut;   // force all lamps dark
    logic loadOut;    // capture demultiplexed lamp word
  } scanStrobe_t;
endpackage

// File: rtl/door_scan_ctrl.sv
module door_scan_ctrl
  import door_scan_pkg::*;
#(
  parameter int NUM_DOORS = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         scanTick,
  output logic [$clog2(NUM_DOORS)-1:0] slot,
  output scanStrobe_t                  strobe
);
  localparam int SEL_W = $clog2(NUM_DOORS);
  localparam logic [SEL_W-1:0] LAST_SLOT = SEL_W'(NUM_DOORS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= '0;
    end else if (scanTick) begin
      if (slot == LAST_SLOT) slot <= '0;
      else                   slot <= slot + 1'b1;
    end
  end

  always_comb begin
    strobe.clearOut = rst;
    strobe.loadOut  = ~rst;
  end

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !scanTick |=> $stable(slot)); // R2
  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (scanTick && slot == LAST_SLOT) |=> (slot == '0)); // R3
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    slot <= LAST_SLOT); // R3
endmodule

// File: rtl/door_scan_path.sv
module door_scan_path
  import door_scan_pkg::*;
#(
  parameter int NUM_DOORS = 8
) (
  input  logic                         clk,
  input  logic [NUM_DOORS-1:0]         doorClosed,
  input  logic [$clog2(NUM_DOORS)-1:0] slot,
  input  scanStrobe_t                  strobe,
  output logic                         serialBit,
  output logic [NUM_DOORS-1:0]         ledN
);
  localparam int SEL_W = $clog2(NUM_DOORS);

  logic [NUM_DOORS-1:0] ledNext;

  // Sensor-side multiplexer onto the single serial line
  assign serialBit = doorClosed[slot];

  // Guard-side demultiplexer: unselected lamps stay HIGH (dark)
  for (genvar g = 0; g < NUM_DOORS; g++) begin : g_demux
    assign ledNext[g] = (slot == SEL_W'(g)) ? serialBit : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.clearOut)     ledN <= '1;
    else if (strobe.loadOut) ledN <= ledNext;
  end

  AST_ONE_LIT: assert property (@(posedge clk) disable iff (strobe.clearOut)
    $countones(~ledN) <= 1); // R7
  AST_LED_FOLLOWS: assert property (@(posedge clk) disable iff (strobe.clearOut)
    1'b1 |=> (ledN[$past(slot)] == $past(serialBit))); // R5
  AST_ALL_CLOSED_DARK: assert property (@(posedge clk) disable iff (strobe.clearOut)
    (doorClosed == '1) |=> (ledN == '1)); // R8
endmodule

// File: rtl/door_scan_monitor.sv
module door_scan_monitor
  import door_scan_pkg::*;
#(
  parameter int NUM_DOORS = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         scanTick,
  input  logic [NUM_DOORS-1:0]         doorClosed,
  output logic [NUM_DOORS-1:0]         ledN,
  output logic [$clog2(NUM_DOORS)-1:0] scanSel,
  output logic                         serialBit
);
  scanStrobe_t strobe;

  door_scan_ctrl #(.NUM_DOORS(NUM_DOORS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .scanTick (scanTick),
    .slot     (scanSel),
    .strobe   (strobe)
  );

  door_scan_path #(.NUM_DOORS(NUM_DOORS)) u_path (
    .clk        (clk),
    .doorClosed (doorClosed),
    .slot       (scanSel),
    .strobe     (strobe),
    .serialBit  (serialBit),
    .ledN       (ledN)
  );
endmodule

// File: tb/door_scan_monitor_bench.sv
module door_scan_monitor_bench;
  localparam int N = 8;
  localparam int TICK_GAP = 4;
  localparam logic [N-1:0] VEC [4] = '{8'hFF, 8'h00, 8'hA5, 8'h3C};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         scanTick = 1'b0;
  logic [N-1:0] doorClosed = '1;
  logic [N-1:0] ledN;
  logic [2:0]   scanSel;
  logic         serialBit;

  int checks = 0;
  int fails  = 0;
  int expSlot = 0;
  logic [N-1:0] expLed = '1;
  bit done = 1'b0;

  always #10 clk = ~clk;

  door_scan_monitor #(.NUM_DOORS(N)) u_door_scan_monitor (
    .clk(clk), .rst(rst), .scanTick(scanTick), .doorClosed(doorClosed),
    .ledN(ledN), .scanSel(scanSel), .serialBit(serialBit)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, update model after posedge, settle at next negedge
  task automatic step(input bit tick);
    @(negedge clk);
    scanTick = tick;
    @(posedge clk);
    if (rst) begin
      expSlot = 0;
      expLed  = '1;
    end else begin
      expLed = '1;
      expLed[expSlot] = doorClosed[expSlot];
      if (tick) expSlot = (expSlot + 1) % N;
    end
    @(negedge clk);
    scanTick = 1'b0;
  endtask

  task automatic checkAll(input string tag);
    chk(scanSel == 3'(expSlot), {tag, " R2 scanSel"}, 32'(scanSel), 32'(expSlot));
    chk(serialBit == doorClosed[expSlot], {tag, " R4 serialBit"}, 32'(serialBit), 32'(doorClosed[expSlot]));
    chk(ledN == expLed, {tag, " R5/R6 ledN"}, 32'(ledN), 32'(expLed));
    chk($countones(~ledN) <= 1, {tag, " R7 one lit"}, 32'($countones(~ledN)), 32'd1);
  endtask

  initial begin
    int lowCnt [N];
    logic [N-1:0] held;
    // R1: reset state
    step(1'b0);
    step(1'b1);
    chk(scanSel == 3'd0, "R1 reset scanSel", 32'(scanSel), 32'd0);
    chk(ledN == '1, "R1 reset ledN", 32'(ledN), 32'hFF);
    rst = 1'b0;

    // Vector table walk: each pattern over a full scan with held gaps
    for (int v = 0; v < 4; v++) begin
      doorClosed = VEC[v];
      for (int s = 0; s < N; s++) begin
        step(1'b1);
        checkAll("vec tick");
        for (int h = 1; h < TICK_GAP; h++) begin
          step(1'b0);
          checkAll("vec hold");
        end
      end
    end

    // R3: wrap from the last slot to slot 0
    while (expSlot != N - 1) step(1'b1);
    chk(scanSel == 3'd7, "R3 at last slot", 32'(scanSel), 32'd7);
    step(1'b1);
    chk(scanSel == 3'd0, "R3 wrap to 0", 32'(scanSel), 32'd0);

    // R9: toggle an unselected door, lamps unchanged
    doorClosed = 8'h00;
    step(1'b0);
    step(1'b0);
    held = ledN;
    doorClosed[5] = 1'b1;
    step(1'b0);
    chk(ledN == held, "R9 unselected change", 32'(ledN), 32'(held));
    doorClosed[5] = 1'b0;
    step(1'b0);
    chk(ledN == held, "R9 unselected restore", 32'(ledN), 32'(held));

    // R8: blink duty over one full scan period with evenly spaced ticks
    doorClosed = 8'b1001_0110;
    for (int i = 0; i < N; i++) lowCnt[i] = 0;
    for (int c = 0; c < N * TICK_GAP; c++) begin
      step((c % TICK_GAP) == 0);
      for (int i = 0; i < N; i++) if (!ledN[i]) lowCnt[i]++;
    end
    for (int i = 0; i < N; i++)
      chk(lowCnt[i] == (doorClosed[i] ? 0 : TICK_GAP), "R8 blink duty",
          32'(lowCnt[i]), 32'(doorClosed[i] ? 0 : TICK_GAP));

    // R1: reset in mid-scan with open doors
    doorClosed = 8'h00;
    step(1'b1);
    step(1'b1);
    rst = 1'b1;
    step(1'b1);
    chk(scanSel == 3'd0, "R1 mid-scan reset scanSel", 32'(scanSel), 32'd0);
    chk(ledN == '1, "R1 mid-scan reset ledN", 32'(ledN), 32'hFF);
    rst = 1'b0;
    step(1'b0);
    checkAll("post reset");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule